// File: doc/BRIEF.md
# Counted Loop Rotation Controller

This block carries the state behind a counted, software-pipelined loop: an iteration counter, a drain counter and two rename offsets, one for a rotating window of general registers and one for a rotating window of predicate registers. Each loop-branch strobe advances all of this state in a single cycle. In the same cycle it reports whether the branch is taken and which value is written into the lowest rotating predicate. That predicate turns the first pipeline stage on or off, so prologue and epilogue code is not needed.

Two kinds of branch share the same state update. A continue-type branch is taken while the loop is filling or draining. An exit-type branch gives the opposite decision. Before the loop starts, software loads the iteration counter with the trip count minus one and the drain counter with the number of pipeline stages. It may also clear the rename offsets. Two combinational translators turn logical register numbers into physical ones, using the current offsets.

Top module: `rot_loop_ctl`

## Requirements
- R1: On a branch strobe with a nonzero iteration counter, the iteration counter drops by one, the drain counter holds and both rename offsets move down by one.
- R2: On a branch strobe with the iteration counter at zero and the drain counter above one, the drain counter drops by one, the iteration counter stays zero and both offsets move down by one.
- R3: On a branch strobe with the iteration counter at zero and the drain counter at one, the drain counter becomes zero and both offsets move down by one.
- R4: On a branch strobe with both counters at zero, the counters and both offsets keep their values.
- R5: A continue-type branch (`br_cont_i`) is taken exactly when the iteration counter is nonzero or the drain counter is above one. An exit-type branch (`br_exit_i`) is taken in the other cases. When both strobes are high, the continue-type decision applies. `br_taken_o` is low when no strobe is present.
- R6: On every strobe, `pred_wr_en_o` is high and `pred_inj_o` is 1 exactly when the iteration counter was nonzero. `pred_wr_idx_o` equals PR_LO plus the predicate offset after the update, which is the physical slot of the lowest rotating predicate after rotation.
- R7: A general logical number g with GR_LO <= g < GR_LO+GR_ROT maps to GR_LO + ((g - GR_LO + gr_base) mod GR_ROT). An offset that moves down from 0 wraps to GR_ROT-1.
- R8: A predicate logical number p with PR_LO <= p < PR_LO+PR_ROT maps to PR_LO + ((p - PR_LO + pr_base) mod PR_ROT). An offset that moves down from 0 wraps to PR_ROT-1.
- R9: Logical numbers outside their rotating window map to themselves.
- R10: `base_clr_i` without a strobe sets both offsets to zero on the next edge. With a strobe in the same cycle it is ignored.
- R11: `lc_load_i` or `ec_load_i` without a strobe loads its counter on the next edge. With a strobe in the same cycle the load is ignored and the branch update applies.
- R12: After reset both counters and both offsets are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_cont_i | input | 1 | Continue-type loop branch strobe |
| br_exit_i | input | 1 | Exit-type loop branch strobe |
| lc_load_i | input | 1 | Load iteration counter |
| lc_load_val_i | input | LC_W | Iteration counter load value (trip count minus one) |
| ec_load_i | input | 1 | Load drain counter |
| ec_load_val_i | input | EC_W | Drain counter load value (stage count) |
| base_clr_i | input | 1 | Clear both rename offsets |
| gr_log_i | input | GR_IDX_W | Logical general register number to translate |
| pr_log_i | input | PR_IDX_W | Logical predicate number to translate |
| br_taken_o | output | 1 | Branch decision for the current strobe |
| pred_wr_en_o | output | 1 | Stage predicate write enable |
| pred_wr_idx_o | output | PR_IDX_W | Physical predicate receiving the stage value |
| pred_inj_o | output | 1 | Stage predicate value |
| lc_o | output | LC_W | Iteration counter |
| ec_o | output | EC_W | Drain counter |
| gr_base_o | output | $clog2(GR_ROT) | General rename offset |
| pr_base_o | output | $clog2(PR_ROT) | Predicate rename offset |
| gr_phys_o | output | GR_IDX_W | Physical general register number |
| pr_phys_o | output | PR_IDX_W | Physical predicate number |

## Verification
The bench uses a 16-bit iteration counter, a 6-bit drain counter, an eight-entry general window starting at 32 and the 48-entry predicate window from 16 to 63. The small general window wraps within a seven-rotation loop. A 51-rotation run wraps the predicate offset through 47 as well. At several offsets, including zero after a clear, every logical number of both files is translated. This covers the window edges and the pass-through ranges on both sides.

// File: rtl/rot_loop_pkg.sv
// Shared types for the counted loop rotation controller.
// Assumes: nothing beyond IEEE 1800-2017.
package rot_loop_pkg;

    // Which branch case applies to the current counter values.
    typedef enum logic [1:0] {
        STEP_KERNEL = 2'd0,  // iteration counter nonzero
        STEP_DRAIN  = 2'd1,  // iteration zero, drain above one
        STEP_LAST   = 2'd2,  // iteration zero, drain exactly one
        STEP_IDLE   = 2'd3   // both zero
    } step_kind_e;

endpackage

// File: rtl/rot_loop_step.sv
// Combinational next-state logic for one counted loop branch.
// Classifies the counter pair and returns the updated counters, the rotate
// request, the stage predicate value and the continue-type decision.
// Assumes: the caller applies the results only when a strobe is present.
module rot_loop_step
    import rot_loop_pkg::*;
#(
    parameter int LC_W = 16,
    parameter int EC_W = 6
) (
    input  logic [LC_W-1:0] lc_i,
    input  logic [EC_W-1:0] ec_i,
    output logic [LC_W-1:0] lc_nxt_o,
    output logic [EC_W-1:0] ec_nxt_o,
    output logic            rotate_o,
    output logic            inject_o,
    output logic            cont_taken_o
);

    step_kind_e kind;

    // Classify the counter pair into one of the four branch cases.
    always_comb begin
        if (lc_i != '0)
            kind = STEP_KERNEL;
        else if (ec_i > EC_W'(1))
            kind = STEP_DRAIN;
        else if (ec_i == EC_W'(1))
            kind = STEP_LAST;
        else
            kind = STEP_IDLE;
    end

    // Produce the counter updates and side effects of the selected case.
    always_comb begin
        lc_nxt_o     = lc_i;
        ec_nxt_o     = ec_i;
        rotate_o     = 1'b0;
        inject_o     = 1'b0;
        cont_taken_o = 1'b0;
        case (kind)
            STEP_KERNEL: begin
                lc_nxt_o     = lc_i - LC_W'(1);
                rotate_o     = 1'b1;
                inject_o     = 1'b1;
                cont_taken_o = 1'b1;
            end
            STEP_DRAIN: begin
                ec_nxt_o     = ec_i - EC_W'(1);
                rotate_o     = 1'b1;
                cont_taken_o = 1'b1;
            end
            STEP_LAST: begin
                ec_nxt_o     = '0;
                rotate_o     = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/rot_base_ctr.sv
// Modular down-counting rename offset for one rotating window.
// Moving down from zero wraps to SIZE-1. A clear forces zero. The decrement
// has priority over the clear. base_nxt_o exposes the value of the next edge.
// Assumes: SIZE >= 2.
module rot_base_ctr #(
    parameter int SIZE = 8,
    localparam int BW  = $clog2(SIZE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_i,
    input  logic          clr_i,
    output logic [BW-1:0] base_o,
    output logic [BW-1:0] base_nxt_o
);

    logic [BW-1:0] base_q;

    // Compute the offset for the next edge.
    always_comb begin
        if (dec_i)
            base_nxt_o = (base_q == '0) ? BW'(SIZE - 1) : base_q - BW'(1);
        else if (clr_i)
            base_nxt_o = '0;
        else
            base_nxt_o = base_q;
    end

    // Hold the offset, zero under reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else
            base_q <= base_nxt_o;
    end

    assign base_o = base_q;

endmodule

// File: rtl/rot_rename.sv
// Logical-to-physical register translation for one rotating window.
// A number inside [LO, LO+SIZE) is offset by base modulo SIZE. Any other
// number passes through unchanged.
// Assumes: LO+SIZE <= 2**IDX_W and base_i < SIZE.
module rot_rename #(
    parameter int IDX_W = 7,
    parameter int LO    = 32,
    parameter int SIZE  = 8,
    localparam int BW   = $clog2(SIZE)
) (
    input  logic [IDX_W-1:0] log_i,
    input  logic [BW-1:0]    base_i,
    output logic [IDX_W-1:0] phys_o
);

    localparam int SW = IDX_W + 1;

    logic [SW-1:0] log_x;
    logic [SW-1:0] off;
    logic [SW-1:0] sum;
    logic          in_win;

    // Translate: window-relative offset, add base, fold once, rebase.
    always_comb begin
        log_x  = SW'(log_i);
        in_win = (log_x >= SW'(LO)) && (log_x < SW'(LO + SIZE));
        off    = log_x - SW'(LO);
        sum    = off + SW'(base_i);
        if (sum >= SW'(SIZE))
            sum = sum - SW'(SIZE);
        phys_o = in_win ? IDX_W'(SW'(LO) + sum) : log_i;
    end

endmodule

// File: rtl/rot_loop_ctl.sv
// Counted loop rotation controller, top level.
// Holds the iteration and drain counters. On a loop-branch strobe it applies
// the branch case in one cycle, rotates both rename windows and reports the
// decision and the stage predicate. Loads and clears act only in cycles
// without a strobe.
// Assumes: GR_ROT >= 2, PR_ROT >= 2, windows fit their index widths.
module rot_loop_ctl #(
    parameter int LC_W     = 16,
    parameter int EC_W     = 6,
    parameter int GR_IDX_W = 7,
    parameter int GR_LO    = 32,
    parameter int GR_ROT   = 8,
    parameter int PR_IDX_W = 6,
    parameter int PR_LO    = 16,
    parameter int PR_ROT   = 48
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      br_cont_i,
    input  logic                      br_exit_i,
    input  logic                      lc_load_i,
    input  logic [LC_W-1:0]           lc_load_val_i,
    input  logic                      ec_load_i,
    input  logic [EC_W-1:0]           ec_load_val_i,
    input  logic                      base_clr_i,
    input  logic [GR_IDX_W-1:0]       gr_log_i,
    input  logic [PR_IDX_W-1:0]       pr_log_i,
    output logic                      br_taken_o,
    output logic                      pred_wr_en_o,
    output logic [PR_IDX_W-1:0]       pred_wr_idx_o,
    output logic                      pred_inj_o,
    output logic [LC_W-1:0]           lc_o,
    output logic [EC_W-1:0]           ec_o,
    output logic [$clog2(GR_ROT)-1:0] gr_base_o,
    output logic [$clog2(PR_ROT)-1:0] pr_base_o,
    output logic [GR_IDX_W-1:0]       gr_phys_o,
    output logic [PR_IDX_W-1:0]       pr_phys_o
);

    localparam int GR_BW = $clog2(GR_ROT);
    localparam int PR_BW = $clog2(PR_ROT);

    logic            strobe;
    logic [LC_W-1:0] lc_q;
    logic [EC_W-1:0] ec_q;
    logic [LC_W-1:0] lc_nxt;
    logic [EC_W-1:0] ec_nxt;
    logic            rotate;
    logic            inject;
    logic            cont_taken;
    logic            clr_eff;
    logic [GR_BW-1:0] gr_base_nxt;
    logic [PR_BW-1:0] pr_base_nxt;

    // Either branch kind starts a loop-branch update.
    assign strobe  = br_cont_i | br_exit_i;
    assign clr_eff = base_clr_i & ~strobe;

    rot_loop_step #(
        .LC_W (LC_W),
        .EC_W (EC_W)
    ) u_step (
        .lc_i         (lc_q),
        .ec_i         (ec_q),
        .lc_nxt_o     (lc_nxt),
        .ec_nxt_o     (ec_nxt),
        .rotate_o     (rotate),
        .inject_o     (inject),
        .cont_taken_o (cont_taken)
    );

    // Counter registers: the branch update wins, otherwise software loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lc_q <= '0;
            ec_q <= '0;
        end else if (strobe) begin
            lc_q <= lc_nxt;
            ec_q <= ec_nxt;
        end else begin
            if (lc_load_i)
                lc_q <= lc_load_val_i;
            if (ec_load_i)
                ec_q <= ec_load_val_i;
        end
    end

    rot_base_ctr #(
        .SIZE (GR_ROT)
    ) u_gr_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_i      (strobe & rotate),
        .clr_i      (clr_eff),
        .base_o     (gr_base_o),
        .base_nxt_o (gr_base_nxt)
    );

    rot_base_ctr #(
        .SIZE (PR_ROT)
    ) u_pr_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_i      (strobe & rotate),
        .clr_i      (clr_eff),
        .base_o     (pr_base_o),
        .base_nxt_o (pr_base_nxt)
    );

    rot_rename #(
        .IDX_W (GR_IDX_W),
        .LO    (GR_LO),
        .SIZE  (GR_ROT)
    ) u_gr_map (
        .log_i  (gr_log_i),
        .base_i (gr_base_o),
        .phys_o (gr_phys_o)
    );

    rot_rename #(
        .IDX_W (PR_IDX_W),
        .LO    (PR_LO),
        .SIZE  (PR_ROT)
    ) u_pr_map (
        .log_i  (pr_log_i),
        .base_i (pr_base_o),
        .phys_o (pr_phys_o)
    );

    // Slot of the lowest rotating predicate once this branch has rotated.
    rot_rename #(
        .IDX_W (PR_IDX_W),
        .LO    (PR_LO),
        .SIZE  (PR_ROT)
    ) u_inj_map (
        .log_i  (PR_IDX_W'(PR_LO)),
        .base_i (pr_base_nxt),
        .phys_o (pred_wr_idx_o)
    );

    // Decision: the continue kind takes priority when both strobes are high.
    assign br_taken_o   = strobe & (br_cont_i ? cont_taken : ~cont_taken);
    assign pred_wr_en_o = strobe;
    assign pred_inj_o   = strobe & inject;
    assign lc_o         = lc_q;
    assign ec_o         = ec_q;

endmodule

// File: rtl/rot_loop_ctl_chk.sv
// Property checker for rot_loop_ctl. It is attached through bind and
// observes ports only.
module rot_loop_ctl_chk #(
    parameter int LC_W     = 16,
    parameter int EC_W     = 6,
    parameter int GR_IDX_W = 7,
    parameter int GR_LO    = 32,
    parameter int GR_ROT   = 8,
    parameter int PR_IDX_W = 6,
    parameter int PR_LO    = 16,
    parameter int PR_ROT   = 48
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      br_cont_i,
    input logic                      br_exit_i,
    input logic                      base_clr_i,
    input logic [GR_IDX_W-1:0]       gr_log_i,
    input logic [PR_IDX_W-1:0]       pr_log_i,
    input logic                      br_taken_o,
    input logic                      pred_wr_en_o,
    input logic                      pred_inj_o,
    input logic [LC_W-1:0]           lc_o,
    input logic [EC_W-1:0]           ec_o,
    input logic [$clog2(GR_ROT)-1:0] gr_base_o,
    input logic [$clog2(PR_ROT)-1:0] pr_base_o,
    input logic [GR_IDX_W-1:0]       gr_phys_o,
    input logic [PR_IDX_W-1:0]       pr_phys_o
);

    logic br_any;
    assign br_any = br_cont_i | br_exit_i;

    a_r1_kernel_step: assert property (@(posedge clk) disable iff (!rst_n)
        (br_any && lc_o != '0) |=> (lc_o == $past(lc_o) - LC_W'(1)) && (ec_o == $past(ec_o)));

    a_r2_drain_step: assert property (@(posedge clk) disable iff (!rst_n)
        (br_any && lc_o == '0 && ec_o > EC_W'(1)) |=> (lc_o == '0) && (ec_o == $past(ec_o) - EC_W'(1)));

    a_r3_last_step: assert property (@(posedge clk) disable iff (!rst_n)
        (br_any && lc_o == '0 && ec_o == EC_W'(1)) |=> (lc_o == '0) && (ec_o == '0));

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (br_any && lc_o == '0 && ec_o == '0) |=>
            $stable(lc_o) && $stable(ec_o) && $stable(gr_base_o) && $stable(pr_base_o));

    a_r5_cont_decision: assert property (@(posedge clk) disable iff (!rst_n)
        br_cont_i |-> (br_taken_o == ((lc_o != '0) || (ec_o > EC_W'(1)))));

    a_r5_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !br_any |-> !br_taken_o && !pred_wr_en_o);

    a_r6_inject_value: assert property (@(posedge clk) disable iff (!rst_n)
        br_any |-> pred_wr_en_o && (pred_inj_o == (lc_o != '0)));

    a_r7_gr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(gr_log_i) >= GR_LO && int'(gr_log_i) < GR_LO + GR_ROT) |->
            (int'(gr_phys_o) >= GR_LO && int'(gr_phys_o) < GR_LO + GR_ROT));

    a_r9_pr_below_window: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pr_log_i) < PR_LO) |-> (pr_phys_o == pr_log_i));

    a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (base_clr_i && !br_any) |=> (gr_base_o == '0) && (pr_base_o == '0));

endmodule

bind rot_loop_ctl rot_loop_ctl_chk #(
    .LC_W     (LC_W),
    .EC_W     (EC_W),
    .GR_IDX_W (GR_IDX_W),
    .GR_LO    (GR_LO),
    .GR_ROT   (GR_ROT),
    .PR_IDX_W (PR_IDX_W),
    .PR_LO    (PR_LO),
    .PR_ROT   (PR_ROT)
) u_chk (.*);

// File: tb/tb_rot_loop_ctl.sv
`timescale 1ns/1ps
// Directed bench for rot_loop_ctl. A reference model of the counters and
// offsets is kept from the requirements.
module tb_rot_loop_ctl;

    localparam int LC_W = 16, EC_W = 6;
    localparam int GR_IDX_W = 7, GR_LO = 32, GR_ROT = 8;
    localparam int PR_IDX_W = 6, PR_LO = 16, PR_ROT = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic br_cont_i = 1'b0, br_exit_i = 1'b0;
    logic lc_load_i = 1'b0, ec_load_i = 1'b0, base_clr_i = 1'b0;
    logic [LC_W-1:0] lc_load_val_i = '0;
    logic [EC_W-1:0] ec_load_val_i = '0;
    logic [GR_IDX_W-1:0] gr_log_i = '0;
    logic [PR_IDX_W-1:0] pr_log_i = '0;
    logic br_taken_o, pred_wr_en_o, pred_inj_o;
    logic [PR_IDX_W-1:0] pred_wr_idx_o;
    logic [LC_W-1:0] lc_o;
    logic [EC_W-1:0] ec_o;
    logic [$clog2(GR_ROT)-1:0] gr_base_o;
    logic [$clog2(PR_ROT)-1:0] pr_base_o;
    logic [GR_IDX_W-1:0] gr_phys_o;
    logic [PR_IDX_W-1:0] pr_phys_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    int m_lc = 0, m_ec = 0, m_gb = 0, m_pb = 0;

    always #2 clk = ~clk;

    rot_loop_ctl #(
        .LC_W(LC_W), .EC_W(EC_W), .GR_IDX_W(GR_IDX_W), .GR_LO(GR_LO),
        .GR_ROT(GR_ROT), .PR_IDX_W(PR_IDX_W), .PR_LO(PR_LO), .PR_ROT(PR_ROT)
    ) dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int map_ref(input int lg, input int lo, input int sz, input int b);
        if (lg >= lo && lg < lo + sz) return lo + ((lg - lo + b) % sz);
        return lg;
    endfunction

    // Compare the registered state with the model.
    task automatic chk_state(input string req);
        chk(int'(lc_o) == m_lc, {req, " lc"}, int'(lc_o), m_lc);
        chk(int'(ec_o) == m_ec, {req, " ec"}, int'(ec_o), m_ec);
        chk(int'(gr_base_o) == m_gb, {req, " gr_base"}, int'(gr_base_o), m_gb);
        chk(int'(pr_base_o) == m_pb, {req, " pr_base"}, int'(pr_base_o), m_pb);
    endtask

    // One loop branch: check the decision, then the state after the edge.
    task automatic do_branch(input bit cont, input bit ext, input string req);
        bit ct, exp_t, exp_inj, rot;
        @(negedge clk);
        br_cont_i = cont; br_exit_i = ext;
        #1;
        ct = (m_lc != 0) || (m_ec > 1);
        exp_t = cont ? ct : !ct;
        exp_inj = (m_lc != 0);
        rot = (m_lc != 0) || (m_ec != 0);
        if (m_lc != 0) m_lc--;
        else if (m_ec > 0) m_ec--;
        if (rot) begin
            m_gb = (m_gb + GR_ROT - 1) % GR_ROT;
            m_pb = (m_pb + PR_ROT - 1) % PR_ROT;
        end
        chk(br_taken_o == exp_t, {req, " R5 taken"}, int'(br_taken_o), int'(exp_t));
        chk(pred_inj_o == exp_inj, {req, " R6 inject"}, int'(pred_inj_o), int'(exp_inj));
        chk(pred_wr_en_o == 1'b1, "R6 wr_en", int'(pred_wr_en_o), 1);
        chk(int'(pred_wr_idx_o) == PR_LO + m_pb, "R6 wr_idx", int'(pred_wr_idx_o), PR_LO + m_pb);
        @(negedge clk);
        br_cont_i = 1'b0; br_exit_i = 1'b0;
        chk_state(req);
    endtask

    task automatic load(input int lc, input int ec);
        @(negedge clk);
        lc_load_i = 1'b1; ec_load_i = 1'b1;
        lc_load_val_i = LC_W'(lc); ec_load_val_i = EC_W'(ec);
        @(negedge clk);
        lc_load_i = 1'b0; ec_load_i = 1'b0;
        m_lc = lc; m_ec = ec;
        chk_state("R11 load");
    endtask

    // Kind of branch that the model expects for the current counters.
    function automatic string case_tag();
        if (m_lc != 0) return "R1";
        if (m_ec > 1) return "R2";
        if (m_ec == 1) return "R3";
        return "R4";
    endfunction

    task automatic t_reset();
        #1;
        chk_state("R12 reset");
        chk(br_taken_o == 1'b0, "R5 idle taken", int'(br_taken_o), 0);
    endtask

    // Continue-type loop, run until it falls through.
    task automatic t_cont_loop(input int lc, input int ec);
        bit fell;
        load(lc, ec);
        fell = 0;
        for (int i = 0; i < 200 && !fell; i++) begin
            fell = (m_lc == 0 && m_ec <= 1);
            do_branch(1'b1, 1'b0, case_tag());
        end
        chk(m_lc == 0 && m_ec == 0, "R3 loop drained", m_ec, 0);
    endtask

    // Exit-type loop, run until it is taken.
    task automatic t_exit_loop(input int lc, input int ec);
        bit last;
        load(lc, ec);
        last = 0;
        for (int i = 0; i < 200 && !last; i++) begin
            last = (m_lc == 0 && m_ec <= 1);
            do_branch(1'b0, 1'b1, case_tag());
        end
    endtask

    task automatic t_idle();
        do_branch(1'b1, 1'b0, "R4 idle cont");
        do_branch(1'b0, 1'b1, "R4 idle exit");
    endtask

    task automatic t_both();
        load(1, 2);
        do_branch(1'b1, 1'b1, "R5 both strobes");
        do_branch(1'b1, 1'b1, "R5 both strobes");
    endtask

    task automatic t_ignored();
        int gb0, pb0;
        load(0, 0);
        gb0 = m_gb; pb0 = m_pb;
        @(negedge clk);
        br_cont_i = 1'b1; lc_load_i = 1'b1; lc_load_val_i = 16'd9;
        ec_load_i = 1'b1; ec_load_val_i = 6'd5; base_clr_i = 1'b1;
        @(negedge clk);
        br_cont_i = 1'b0; lc_load_i = 1'b0; ec_load_i = 1'b0; base_clr_i = 1'b0;
        chk(int'(lc_o) == 0, "R11 load ignored under strobe", int'(lc_o), 0);
        chk(int'(ec_o) == 0, "R11 load ignored under strobe", int'(ec_o), 0);
        chk(int'(gr_base_o) == gb0, "R10 clear ignored under strobe", int'(gr_base_o), gb0);
        chk(int'(pr_base_o) == pb0, "R10 clear ignored under strobe", int'(pr_base_o), pb0);
    endtask

    task automatic t_clear();
        @(negedge clk);
        base_clr_i = 1'b1;
        @(negedge clk);
        base_clr_i = 1'b0;
        m_gb = 0; m_pb = 0;
        chk_state("R10 clear");
    endtask

    // Sweep every logical number of both files at the current offsets.
    task automatic t_rename();
        int e;
        for (int g = 0; g < (1 << GR_IDX_W); g++) begin
            @(negedge clk);
            gr_log_i = GR_IDX_W'(g);
            #1;
            e = map_ref(g, GR_LO, GR_ROT, m_gb);
            if (g >= GR_LO && g < GR_LO + GR_ROT)
                chk(int'(gr_phys_o) == e, "R7 gr map", int'(gr_phys_o), e);
            else
                chk(int'(gr_phys_o) == e, "R9 gr pass", int'(gr_phys_o), e);
        end
        for (int p = 0; p < (1 << PR_IDX_W); p++) begin
            @(negedge clk);
            pr_log_i = PR_IDX_W'(p);
            #1;
            e = map_ref(p, PR_LO, PR_ROT, m_pb);
            if (p >= PR_LO && p < PR_LO + PR_ROT)
                chk(int'(pr_phys_o) == e, "R8 pr map", int'(pr_phys_o), e);
            else
                chk(int'(pr_phys_o) == e, "R9 pr pass", int'(pr_phys_o), e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rename();
        t_cont_loop(4, 3);
        t_rename();
        t_idle();
        t_exit_loop(2, 2);
        t_both();
        t_ignored();
        t_cont_loop(50, 1);
        t_rename();
        t_clear();
        t_rename();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule